// File: doc/BRIEF.md
# Conditional Branch Decision Unit

This block decides, for a simple sequencer, whether a jump is taken and which address comes next. Each request carries a 4-bit condition code, the processor's current flag word, the value of a general count register, the address of the instruction that follows the jump (the fall-through address) and the jump's target address. A one-cycle strobe marks a valid request.

One clock edge after the strobe, the unit presents a taken indicator and the chosen next address, together with a one-cycle result strobe. The target may lie below or above the jump; the unit passes it through unchanged. Every flag-based condition comes in a pair: the even code tests for the flag set and the odd code tests for it clear. One condition looks only at the count register, and one jumps always. Codes with no meaning are resolved as not taken.

Top module: `branch_resolve`

## Requirements
- R1: After reset, `out_vld`, `taken` and `next_addr` are all zero.
- R2: A request strobed on `in_vld` at one clock edge produces `out_vld` high for exactly the following cycle. When `in_vld` is low, `taken` and `next_addr` keep their values and `out_vld` is low.
- R3: Code 4'h0 (always) is taken whatever the flags and the count hold.
- R4: Code 4'h2 is taken when the zero flag (flag word bit 6) is 1, and code 4'h3 is taken when it is 0.
- R5: Code 4'h4 is taken when the carry flag (bit 0) is 1, and code 4'h5 is taken when it is 0.
- R6: Codes 4'h6/4'h7 test the sign flag (bit 7), 4'h8/4'h9 the overflow flag (bit 11) and 4'hA/4'hB the parity flag (bit 2). The even code is taken on 1 and the odd code on 0.
- R7: Code 4'h1 is taken exactly when the count value is zero. The flag word has no effect on it.
- R8: Codes 4'hC to 4'hF are never taken.
- R9: `next_addr` equals the target address when the jump is taken and the fall-through address when it is not. Both lower and higher targets are passed through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_vld | input | 1 | Request strobe |
| cond_code | input | 4 | Condition code |
| flag_word | input | FLAG_W (16) | Current flag word |
| count_val | input | CNT_W (16) | Count register value |
| fall_addr | input | ADDR_W (16) | Address of the instruction after the jump |
| tgt_addr | input | ADDR_W (16) | Jump target address |
| out_vld | output | 1 | Result strobe, one cycle after `in_vld` |
| taken | output | 1 | The condition held |
| next_addr | output | ADDR_W (16) | Selected next instruction address |

## Verification
The bench builds the unit with its default values: 16-bit addresses, a 16-bit count register and a 16-bit flag word with the zero, carry, sign, overflow and parity bits at positions 6, 0, 7, 11 and 2. A 16-bit count is wider than one chunk, so the chunked zero detector is the variant under test. The directed cases include counts with a single set bit in either byte. Random requests seldom hit a zero count, so directed cases cover zero counts under all-ones flags, targets below and above the fall-through address, and the unused codes. Idle cycles that present new input values check that the outputs hold.

// File: rtl/branch_resolve_pkg.sv
package branch_resolve_pkg;

   // Condition codes: flag pairs use bit 0 as "test for clear"
   typedef enum logic [3:0] {
      CC_ALWAYS  = 4'h0,
      CC_CNTZERO = 4'h1,
      CC_ZSET    = 4'h2,
      CC_ZCLR    = 4'h3,
      CC_CSET    = 4'h4,
      CC_CCLR    = 4'h5,
      CC_SSET    = 4'h6,
      CC_SCLR    = 4'h7,
      CC_OSET    = 4'h8,
      CC_OCLR    = 4'h9,
      CC_PSET    = 4'hA,
      CC_PCLR    = 4'hB
   } cond_e;

   // Flags extracted from the flag word
   typedef struct packed {
      logic zf;
      logic cf;
      logic sf;
      logic of;
      logic pf;
   } flag_t;

   localparam int CODE_W = 4;

endpackage

// File: rtl/branch_resolve_cntz.sv
module branch_resolve_cntz #(
   parameter int CNT_W = 16,
   parameter int CHUNK = 8
) (
   input  logic [CNT_W-1:0] cnt,
   output logic             is_zero
);
   localparam int NCH = (CNT_W + CHUNK - 1) / CHUNK;

   generate
      if (CNT_W <= CHUNK) begin : g_flat
         assign is_zero = ~|cnt;
      end else begin : g_chunked
         logic [NCH-1:0] nz;
         for (genvar i = 0; i < NCH; i++) begin : g_ch
            localparam int LO = i * CHUNK;
            localparam int HI = ((LO + CHUNK) > CNT_W) ? CNT_W - 1 : LO + CHUNK - 1;
            assign nz[i] = |cnt[HI:LO];
         end
         assign is_zero = ~|nz;
      end
   endgenerate
endmodule

// File: rtl/branch_resolve_eval.sv
module branch_resolve_eval
   import branch_resolve_pkg::*;
(
   input  logic [CODE_W-1:0] code,
   input  flag_t             flags,
   input  logic              cnt_zero,
   output logic              hit
);
   logic sel;

   always_comb begin
      sel = 1'b0;
      case (code[3:1])
         3'd1:    sel = flags.zf;
         3'd2:    sel = flags.cf;
         3'd3:    sel = flags.sf;
         3'd4:    sel = flags.of;
         3'd5:    sel = flags.pf;
         default: sel = 1'b0;
      endcase
   end

   always_comb begin
      if (code == CC_ALWAYS)
         hit = 1'b1;
      else if (code == CC_CNTZERO)
         hit = cnt_zero;
      else if (code >= 4'hC)
         hit = 1'b0;
      else
         hit = sel ^ code[0];
   end
endmodule

// File: rtl/branch_resolve_mux.sv
module branch_resolve_mux #(
   parameter int ADDR_W = 16
) (
   input  logic              pick_tgt,
   input  logic [ADDR_W-1:0] fall,
   input  logic [ADDR_W-1:0] tgt,
   output logic [ADDR_W-1:0] addr
);
   assign addr = pick_tgt ? tgt : fall;
endmodule

// File: rtl/branch_resolve.sv
module branch_resolve
   import branch_resolve_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16,
   parameter int FLAG_W = 16,
   parameter int ZF_BIT = 6,
   parameter int CF_BIT = 0,
   parameter int SF_BIT = 7,
   parameter int OF_BIT = 11,
   parameter int PF_BIT = 2,
   parameter int CHUNK  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_vld,
   input  logic [3:0]        cond_code,
   input  logic [FLAG_W-1:0] flag_word,
   input  logic [CNT_W-1:0]  count_val,
   input  logic [ADDR_W-1:0] fall_addr,
   input  logic [ADDR_W-1:0] tgt_addr,
   output logic              out_vld,
   output logic              taken,
   output logic [ADDR_W-1:0] next_addr
);
   localparam int MAX_BIT = FLAG_W - 1;

   generate
      if (ZF_BIT > MAX_BIT || CF_BIT > MAX_BIT || SF_BIT > MAX_BIT ||
          OF_BIT > MAX_BIT || PF_BIT > MAX_BIT) begin : g_bad_flag
         $error("branch_resolve: flag bit position outside FLAG_W");
      end
      if (ADDR_W < 1 || CNT_W < 1 || CHUNK < 1) begin : g_bad_width
         $error("branch_resolve: widths must be positive");
      end
   endgenerate

   flag_t             flags;
   logic              cnt_zero;
   logic              hit;
   logic [ADDR_W-1:0] sel_addr;

   assign flags.zf = flag_word[ZF_BIT];
   assign flags.cf = flag_word[CF_BIT];
   assign flags.sf = flag_word[SF_BIT];
   assign flags.of = flag_word[OF_BIT];
   assign flags.pf = flag_word[PF_BIT];

   branch_resolve_cntz #(.CNT_W(CNT_W), .CHUNK(CHUNK)) u_cntz (
      .cnt     (count_val),
      .is_zero (cnt_zero)
   );

   branch_resolve_eval u_eval (
      .code     (cond_code),
      .flags    (flags),
      .cnt_zero (cnt_zero),
      .hit      (hit)
   );

   branch_resolve_mux #(.ADDR_W(ADDR_W)) u_mux (
      .pick_tgt (hit),
      .fall     (fall_addr),
      .tgt      (tgt_addr),
      .addr     (sel_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld   <= 1'b0;
         taken     <= 1'b0;
         next_addr <= '0;
      end else begin
         out_vld <= in_vld;
         if (in_vld) begin
            taken     <= hit;
            next_addr <= sel_addr;
         end
      end
   end
endmodule

// File: rtl/branch_resolve_chk.sv
module branch_resolve_chk #(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16,
   parameter int FLAG_W = 16,
   parameter int ZF_BIT = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_vld,
   input logic [3:0]        cond_code,
   input logic [FLAG_W-1:0] flag_word,
   input logic [CNT_W-1:0]  count_val,
   input logic [ADDR_W-1:0] fall_addr,
   input logic [ADDR_W-1:0] tgt_addr,
   input logic              out_vld,
   input logic              taken,
   input logic [ADDR_W-1:0] next_addr
);
   // R2
   vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> out_vld);
   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> (!out_vld && $stable(taken) && $stable(next_addr)));
   // R3
   always_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && cond_code == 4'h0) |=> taken);
   // R4
   zero_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && cond_code == 4'h2) |=> (taken == $past(flag_word[ZF_BIT])));
   // R7
   cnt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && cond_code == 4'h1) |=> (taken == ($past(count_val) == '0)));
   // R8
   bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && cond_code >= 4'hC) |=> !taken);
   // R9
   addr_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> (next_addr == (taken ? $past(tgt_addr) : $past(fall_addr))));
endmodule

bind branch_resolve branch_resolve_chk #(
   .ADDR_W(ADDR_W), .CNT_W(CNT_W), .FLAG_W(FLAG_W), .ZF_BIT(ZF_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .cond_code(cond_code),
   .flag_word(flag_word), .count_val(count_val), .fall_addr(fall_addr),
   .tgt_addr(tgt_addr), .out_vld(out_vld), .taken(taken), .next_addr(next_addr)
);

// File: tb/branch_resolve_tb.sv
module branch_resolve_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_vld = 1'b0;
   logic [3:0]  cond_code = '0;
   logic [15:0] flag_word = '0;
   logic [15:0] count_val = '0;
   logic [15:0] fall_addr = '0;
   logic [15:0] tgt_addr = '0;
   logic        out_vld;
   logic        taken;
   logic [15:0] next_addr;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #5 clk = ~clk;

   branch_resolve u_dut (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .cond_code(cond_code),
      .flag_word(flag_word), .count_val(count_val), .fall_addr(fall_addr),
      .tgt_addr(tgt_addr), .out_vld(out_vld), .taken(taken), .next_addr(next_addr)
   );

   // Expected decision from the requirement text
   function automatic bit model(input logic [3:0] c, input logic [15:0] f,
                                input logic [15:0] n);
      case (c)
         4'h0: return 1'b1;                 // R3
         4'h1: return n == 16'h0;           // R7
         4'h2: return f[6];                 // R4
         4'h3: return !f[6];
         4'h4: return f[0];                 // R5
         4'h5: return !f[0];
         4'h6: return f[7];                 // R6
         4'h7: return !f[7];
         4'h8: return f[11];
         4'h9: return !f[11];
         4'hA: return f[2];
         4'hB: return !f[2];
         default: return 1'b0;              // R8
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Drive one request at a falling edge, check after the next rising edge
   task automatic request(input string req, input logic [3:0] c, input logic [15:0] f,
                          input logic [15:0] n, input logic [15:0] fa, input logic [15:0] ta);
      bit exp_t;
      exp_t = model(c, f, n);
      @(negedge clk);
      in_vld = 1'b1; cond_code = c; flag_word = f; count_val = n;
      fall_addr = fa; tgt_addr = ta;
      @(negedge clk);
      in_vld = 1'b0;
      check({req, " out_vld (R2)"}, {31'd0, out_vld}, 32'd1);
      check({req, " taken"}, {31'd0, taken}, {31'd0, exp_t});
      check({req, " next_addr (R9)"}, {16'd0, next_addr}, {16'd0, exp_t ? ta : fa});
   endtask

   initial begin
      #1000000;
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (2) @(negedge clk);
      // R1 reset state
      check("R1 out_vld", {31'd0, out_vld}, 32'd0);
      check("R1 taken", {31'd0, taken}, 32'd0);
      check("R1 next_addr", {16'd0, next_addr}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // Directed corner cases
      request("R3 always flags0", 4'h0, 16'h0000, 16'h0005, 16'h0102, 16'h0040);
      request("R4 jz set", 4'h2, 16'h0040, 16'h0001, 16'h2000, 16'h1F00);
      request("R4 jz clear", 4'h2, 16'hFFBF, 16'h0001, 16'h2000, 16'h1F00);
      request("R4 jnz", 4'h3, 16'h0000, 16'h0001, 16'h3000, 16'h3400);
      request("R5 jc", 4'h4, 16'h0001, 16'h0000, 16'h0010, 16'h8000);
      request("R5 jnc", 4'h5, 16'h0001, 16'h0000, 16'h0010, 16'h8000);
      request("R6 sign", 4'h6, 16'h0080, 16'h0000, 16'h0011, 16'h0022);
      request("R6 ovf clr", 4'h9, 16'h0800, 16'h0000, 16'h0033, 16'h0044);
      request("R6 par clr", 4'hB, 16'h0000, 16'h0000, 16'h0055, 16'h0066);
      request("R7 cnt zero flags1", 4'h1, 16'hFFFF, 16'h0000, 16'h1000, 16'h0800);
      request("R7 cnt hi bit", 4'h1, 16'h0000, 16'h8000, 16'h1000, 16'h0800);
      request("R7 cnt lo bit", 4'h1, 16'h0000, 16'h0001, 16'h1000, 16'h0800);
      request("R8 code C", 4'hC, 16'hFFFF, 16'h0000, 16'h0200, 16'h0300);
      request("R8 code F", 4'hF, 16'hFFFF, 16'h0000, 16'h0200, 16'h0300);
      request("R9 lower target", 4'h0, 16'h0000, 16'h0000, 16'hFFFE, 16'h0000);

      // R2 hold: idle cycles with changed inputs leave outputs alone
      begin
         logic        t0;
         logic [15:0] a0;
         request("R2 setup", 4'h0, 16'h0000, 16'h0001, 16'h1234, 16'h4321);
         t0 = taken; a0 = next_addr;
         in_vld = 1'b0; cond_code = 4'hD; fall_addr = 16'hAAAA; tgt_addr = 16'h5555;
         @(negedge clk);
         @(negedge clk);
         check("R2 idle out_vld", {31'd0, out_vld}, 32'd0);
         check("R2 idle taken", {31'd0, taken}, {31'd0, t0});
         check("R2 idle next_addr", {16'd0, next_addr}, {16'd0, a0});
      end

      // Constrained random requests over all codes
      for (int i = 0; i < 400; i++) begin
         logic [3:0]  c;
         logic [15:0] f, n;
         c = 4'($urandom_range(0, 15));
         f = 16'($urandom);
         n = ($urandom_range(0, 3) == 0) ? 16'h0 : 16'($urandom);
         request("R4/R5/R6/R7/R8 random", c, f, n, 16'($urandom), 16'($urandom));
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule